// File: doc/BRIEF.md
# Interrupt and Reset Entry Sequencer

This block steers a processor core into one of three entry routines: power-on reset, the non-maskable interrupt and the maskable interrupt. It watches an active-low reset, a level-sensitive active-low maskable request, an active-low non-maskable request that triggers on its falling edge, the current mask flag, an instruction-boundary strobe and the memory ready line. When an entry is taken it pushes the return program counter and the status byte onto the stack page. It then asks the core to set its mask flag and reads a two-byte vector, low byte first. The result leaves as a new program counter.

The reset routine uses the same slot sequence as an interrupt. Three settling cycles come first, then three stack slots, which run as reads so memory is never changed. The vector reads follow. Interrupts are accepted only when the core signals an instruction boundary with ready high. A non-maskable edge is latched, so one that arrives while a sequence is running is serviced at the next boundary. Priority is reset first, then non-maskable, then maskable.

The new program counter leaves on a valid-only stream: `pc_load` is high for exactly one cycle with `pc_new`. There is no back-pressure, and the consumer must take the value in that cycle. The bus side is plain address/data/write-enable with a ready line that stretches read cycles only.

Top module: `irq_entry_seq`

## Requirements
- R1: While `rst_n` is low, `wr_en` and `pc_load` stay low and `busy` is high, whatever the other inputs do.
- R2: After `rst_n` rises, and with `rdy` high, six cycles pass before the low reset vector byte is read at 0xFFFC, followed by 0xFFFD. During the three stack slots of that sequence, `wr_en` stays low.
- R3: A maskable entry starts only on a clock edge where `insn_done`=1, `rdy`=1, `irq_n`=0 and `imask`=0. When any one of these is missing, `busy` stays low and nothing is written.
- R4: An interrupt entry writes three bytes in consecutive cycles with `wr_en`=1: the PC high byte at address 0x0100+SP, the PC low byte at 0x0100+SP-1, and the status at 0x0100+SP-2. SP is the value on `sp_in` at acceptance. After the entry, `sp_out` equals SP-3.
- R5: The maskable vector is read from 0xFFFE (low byte) and then 0xFFFF (high byte). The cycle after the high-byte read, `pc_load` is high for one cycle with `pc_new` = {high byte, low byte}, and `busy` is low.
- R6: A falling edge on `nmi_n` is latched and taken at a boundary even when `imask`=1, with the vector read at 0xFFFA/0xFFFB. Holding `nmi_n` low does not trigger a second entry.
- R7: When a latched non-maskable request and an active maskable request meet at the same boundary, the non-maskable entry is taken first. The maskable one follows at a later boundary if it is still requested.
- R8: A falling edge on `nmi_n` during a running sequence is kept and serviced at the next boundary after that sequence ends.
- R9: A read slot (vector read, or stack slot during reset) holds its address while `rdy` is low and advances when `rdy` is high. Write slots advance every cycle regardless of `rdy`.
- R10: `set_mask` is high for exactly one cycle, the first cycle of the low vector read, for every entry source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low processor reset; also the block's asynchronous reset |
| irq_n | input | 1 | Maskable request, active low, level sensitive |
| nmi_n | input | 1 | Non-maskable request, falling-edge triggered |
| imask | input | 1 | Current interrupt-mask flag of the core |
| insn_done | input | 1 | High in the cycle the current instruction completes |
| rdy | input | 1 | Memory ready; low stretches read slots |
| pc_in | input | ADDR_W | Return program counter to push |
| status_in | input | DATA_W | Status byte to push |
| sp_in | input | DATA_W | Stack pointer at entry |
| rd_data | input | DATA_W | Read data from memory |
| addr | output | ADDR_W | Bus address |
| wr_data | output | DATA_W | Bus write data |
| wr_en | output | 1 | Bus write strobe |
| busy | output | 1 | An entry sequence or reset is in progress |
| set_mask | output | 1 | One-cycle request to set the mask flag |
| sp_out | output | DATA_W | Stack pointer after the pushes |
| pc_load | output | 1 | Valid strobe for `pc_new` (no ready) |
| pc_new | output | ADDR_W | Program counter loaded from the vector |

## Verification
Each accepting edge puts the first push slot on the bus in the following cycle. The two remaining writes follow one cycle apart. `set_mask` and the low vector address appear three cycles after acceptance, the high vector address four cycles after, and `pc_load` five cycles after. After reset release the first stack slot is due after the third edge. The bench drives and samples only on falling clock edges, and one shared task steps through those slots one falling edge at a time, so every comparison lands mid-cycle in the slot where the value is due. Stretched reads are checked by holding `rdy` low and confirming that the address stays put across further falling edges.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_INIT,
    ST_PUSH_H,
    ST_PUSH_L,
    ST_PUSH_P,
    ST_VEC_L,
    ST_VEC_H
  } ies_state_e;

  typedef enum logic [1:0] {
    SRC_RST,
    SRC_NMI,
    SRC_IRQ
  } ies_src_e;

  function automatic logic is_push(ies_state_e s);
    return (s == ST_PUSH_H) || (s == ST_PUSH_L) || (s == ST_PUSH_P);
  endfunction

endpackage

// File: rtl/ies_nmi_latch.sv
module ies_nmi_latch (
  input  logic clk,
  input  logic rst_n,
  input  logic nmi_n,
  input  logic take,
  output logic pend
);
  logic nmi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_q <= 1'b1;
      pend  <= 1'b0;
    end else begin
      nmi_q <= nmi_n;
      // a fresh edge wins over the clear from an acceptance
      if (nmi_q && !nmi_n) pend <= 1'b1;
      else if (take)       pend <= 1'b0;
    end
  end
endmodule

// File: rtl/ies_arbiter.sv
module ies_arbiter
  import irq_entry_pkg::*;
(
  input  logic     idle,
  input  logic     insn_done,
  input  logic     rdy,
  input  logic     nmi_pend,
  input  logic     irq_n,
  input  logic     imask,
  output logic     take,
  output logic     take_nmi,
  output ies_src_e src
);
  logic gate;
  logic irq_ok;

  always_comb begin
    gate     = idle && insn_done && rdy;
    irq_ok   = !irq_n && !imask;
    take     = gate && (nmi_pend || irq_ok);
    take_nmi = gate && nmi_pend;
    src      = nmi_pend ? SRC_NMI : SRC_IRQ;
  end
endmodule

// File: rtl/ies_busmux.sv
module ies_busmux
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STACK_PAGE = 1
) (
  input  ies_state_e        state,
  input  ies_src_e          src,
  input  logic [DATA_W-1:0] sp,
  input  logic [ADDR_W-1:0] pc,
  input  logic [DATA_W-1:0] status,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              read_slot
);
  localparam int PAGE_W = ADDR_W - DATA_W;
  localparam logic [PAGE_W-1:0] PAGE = PAGE_W'(STACK_PAGE);
  localparam logic [ADDR_W-1:0] VEC_TOP = '1;
  localparam logic [ADDR_W-1:0] VEC_NMI = VEC_TOP - ADDR_W'(5);
  localparam logic [ADDR_W-1:0] VEC_RST = VEC_TOP - ADDR_W'(3);
  localparam logic [ADDR_W-1:0] VEC_IRQ = VEC_TOP - ADDR_W'(1);

  logic [ADDR_W-1:0] base;

  always_comb begin
    case (src)
      SRC_RST: base = VEC_RST;
      SRC_NMI: base = VEC_NMI;
      default: base = VEC_IRQ;
    endcase

    wr_data = '0;
    case (state)
      ST_VEC_L: addr = base;
      ST_VEC_H: addr = base + ADDR_W'(1);
      default:  addr = {PAGE, sp};
    endcase
    case (state)
      ST_PUSH_H: wr_data = pc[ADDR_W-1:ADDR_W-DATA_W];
      ST_PUSH_L: wr_data = pc[DATA_W-1:0];
      ST_PUSH_P: wr_data = status;
      default:   wr_data = '0;
    endcase

    wr_en     = is_push(state) && (src != SRC_RST);
    read_slot = (state == ST_VEC_L) || (state == ST_VEC_H) ||
                (is_push(state) && (src == SRC_RST));
  end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
  import irq_entry_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STACK_PAGE = 1,
  parameter int INIT_CYC   = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              irq_n,
  input  logic              nmi_n,
  input  logic              imask,
  input  logic              insn_done,
  input  logic              rdy,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] status_in,
  input  logic [DATA_W-1:0] sp_in,
  input  logic [DATA_W-1:0] rd_data,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              wr_en,
  output logic              busy,
  output logic              set_mask,
  output logic [DATA_W-1:0] sp_out,
  output logic              pc_load,
  output logic [ADDR_W-1:0] pc_new
);
  localparam int CNT_W = (INIT_CYC > 1) ? $clog2(INIT_CYC) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(INIT_CYC - 1);

  ies_state_e        state;
  ies_src_e          src_r;
  ies_src_e          arb_src;
  logic [CNT_W-1:0]  cnt;
  logic [DATA_W-1:0] sp_r;
  logic [ADDR_W-1:0] pc_r;
  logic [DATA_W-1:0] st_r;
  logic [DATA_W-1:0] lo_r;
  logic              take;
  logic              take_nmi;
  logic              nmi_pend;
  logic              read_slot;
  logic              advance;

  ies_nmi_latch u_nmi (
    .clk   (clk),
    .rst_n (rst_n),
    .nmi_n (nmi_n),
    .take  (take_nmi),
    .pend  (nmi_pend)
  );

  ies_arbiter u_arb (
    .idle      (state == ST_IDLE),
    .insn_done (insn_done),
    .rdy       (rdy),
    .nmi_pend  (nmi_pend),
    .irq_n     (irq_n),
    .imask     (imask),
    .take      (take),
    .take_nmi  (take_nmi),
    .src       (arb_src)
  );

  ies_busmux #(
    .ADDR_W     (ADDR_W),
    .DATA_W     (DATA_W),
    .STACK_PAGE (STACK_PAGE)
  ) u_bus (
    .state     (state),
    .src       (src_r),
    .sp        (sp_r),
    .pc        (pc_r),
    .status    (st_r),
    .addr      (addr),
    .wr_data   (wr_data),
    .wr_en     (wr_en),
    .read_slot (read_slot)
  );

  // write slots never wait; read slots wait for ready
  assign advance = !read_slot || rdy;
  assign busy    = (state != ST_IDLE);
  assign sp_out  = sp_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= ST_INIT;
      src_r    <= SRC_RST;
      cnt      <= '0;
      sp_r     <= '0;
      pc_r     <= '0;
      st_r     <= '0;
      lo_r     <= '0;
      pc_new   <= '0;
      pc_load  <= 1'b0;
      set_mask <= 1'b0;
    end else begin
      pc_load  <= 1'b0;
      set_mask <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (take) begin
            state <= ST_PUSH_H;
            src_r <= arb_src;
            sp_r  <= sp_in;
            pc_r  <= pc_in;
            st_r  <= status_in;
          end
        end
        ST_INIT: begin
          sp_r <= sp_in;
          pc_r <= pc_in;
          st_r <= status_in;
          if (cnt == CNT_LAST) begin
            cnt   <= '0;
            state <= ST_PUSH_H;
          end else begin
            cnt <= cnt + CNT_W'(1);
          end
        end
        ST_PUSH_H, ST_PUSH_L, ST_PUSH_P: begin
          if (advance) begin
            sp_r <= sp_r - DATA_W'(1);
            if (state == ST_PUSH_H)      state <= ST_PUSH_L;
            else if (state == ST_PUSH_L) state <= ST_PUSH_P;
            else begin
              state    <= ST_VEC_L;
              set_mask <= 1'b1;
            end
          end
        end
        ST_VEC_L: begin
          if (advance) begin
            lo_r  <= rd_data;
            state <= ST_VEC_H;
          end
        end
        ST_VEC_H: begin
          if (advance) begin
            pc_new  <= {rd_data, lo_r};
            pc_load <= 1'b1;
            state   <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ies_chk.sv
module ies_chk #(
  parameter int ADDR_W     = 16,
  parameter int DATA_W     = 8,
  parameter int STACK_PAGE = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              insn_done,
  input logic              rdy,
  input logic [ADDR_W-1:0] addr,
  input logic              wr_en,
  input logic              busy,
  input logic              set_mask,
  input logic              pc_load
);
  localparam int PAGE_W = ADDR_W - DATA_W;

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |-> (!wr_en && !pc_load));

  // R3
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !(insn_done && rdy)) |=> !busy);

  // R4
  push_page_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (busy && addr[ADDR_W-1:DATA_W] == PAGE_W'(STACK_PAGE)));

  // R5
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !pc_load);

  // R9
  read_stall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !wr_en && !rdy && addr[ADDR_W-1:3] == '1) |=> $stable(addr));

  // R10
  mask_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask |-> (!wr_en && addr[ADDR_W-1:3] == '1));

  // R10
  mask_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_mask |=> !set_mask);
endmodule

bind irq_entry_seq ies_chk #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .STACK_PAGE (STACK_PAGE)
) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .insn_done (insn_done),
  .rdy       (rdy),
  .addr      (addr),
  .wr_en     (wr_en),
  .busy      (busy),
  .set_mask  (set_mask),
  .pc_load   (pc_load)
);

// File: tb/irq_entry_seq_tb_top.sv
module irq_entry_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        irq_n, nmi_n, imask, insn_done, rdy;
  logic [15:0] pc_in;
  logic [7:0]  status_in, sp_in, rd_data;
  logic [15:0] addr, pc_new;
  logic [7:0]  wr_data, sp_out;
  logic        wr_en, busy, set_mask, pc_load;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  always #10 clk = ~clk;

  function automatic logic [7:0] mem_f(logic [15:0] a);
    return a[7:0] ^ 8'hC3;
  endfunction

  assign rd_data = mem_f(addr);

  irq_entry_seq dut_i (
    .clk(clk), .rst_n(rst_n), .irq_n(irq_n), .nmi_n(nmi_n),
    .imask(imask), .insn_done(insn_done), .rdy(rdy),
    .pc_in(pc_in), .status_in(status_in), .sp_in(sp_in),
    .rd_data(rd_data), .addr(addr), .wr_data(wr_data), .wr_en(wr_en),
    .busy(busy), .set_mask(set_mask), .sp_out(sp_out),
    .pc_load(pc_load), .pc_new(pc_new)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called mid-cycle in the first push slot.
  task automatic run_entry(string req, logic [15:0] base, logic exp_wr,
                           logic [7:0] sp0, logic [15:0] pc, logic [7:0] st);
    chk({req, " R4 slot0 addr"}, addr, {8'h01, sp0});
    chk({req, " R4 slot0 we"}, wr_en, exp_wr);
    if (exp_wr) chk({req, " R4 pc hi"}, wr_data, pc[15:8]);
    @(negedge clk);
    chk({req, " R4 slot1 addr"}, addr, {8'h01, sp0 - 8'd1});
    chk({req, " R4 slot1 we"}, wr_en, exp_wr);
    if (exp_wr) chk({req, " R4 pc lo"}, wr_data, pc[7:0]);
    @(negedge clk);
    chk({req, " R4 slot2 addr"}, addr, {8'h01, sp0 - 8'd2});
    if (exp_wr) chk({req, " R4 status"}, wr_data, st);
    @(negedge clk);
    chk({req, " R5 vec lo addr"}, addr, base);
    chk({req, " R5 vec lo read"}, wr_en, 1'b0);
    chk({req, " R10 mask set"}, set_mask, 1'b1);
    @(negedge clk);
    chk({req, " R5 vec hi addr"}, addr, base + 16'd1);
    chk({req, " R10 mask once"}, set_mask, 1'b0);
    @(negedge clk);
    chk({req, " R5 pc_load"}, pc_load, 1'b1);
    chk({req, " R5 pc_new"}, pc_new, {mem_f(base + 16'd1), mem_f(base)});
    chk({req, " R5 idle"}, busy, 1'b0);
    chk({req, " R4 sp_out"}, sp_out, sp0 - 8'd3);
    @(negedge clk);
    chk({req, " R5 pulse"}, pc_load, 1'b0);
  endtask

  task automatic t_reset();
    insn_done = 1'b1; irq_n = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk("R1 no write", wr_en, 1'b0);
      chk("R1 busy", busy, 1'b1);
      chk("R1 no load", pc_load, 1'b0);
    end
    rst_n = 1'b1; insn_done = 1'b0; irq_n = 1'b1;
    repeat (2) begin
      @(negedge clk);
      chk("R2 init busy", busy, 1'b1);
      chk("R2 init no write", wr_en, 1'b0);
    end
    @(negedge clk);
    run_entry("R2 reset", 16'hFFFC, 1'b0, sp_in, pc_in, status_in);
  endtask

  task automatic t_irq_basic();
    sp_in = 8'hF0; pc_in = 16'hBEEF; status_in = 8'h24;
    imask = 1'b0; irq_n = 1'b0; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_n = 1'b1;
    chk("R3 accepted", busy, 1'b1);
    run_entry("R3 irq", 16'hFFFE, 1'b1, 8'hF0, 16'hBEEF, 8'h24);
  endtask

  task automatic t_irq_blocked();
    imask = 1'b1; irq_n = 1'b0; insn_done = 1'b1;
    @(negedge clk);
    chk("R3 masked busy", busy, 1'b0);
    chk("R3 masked we", wr_en, 1'b0);
    imask = 1'b0; insn_done = 1'b0;
    repeat (2) begin
      @(negedge clk);
      chk("R3 no boundary", busy, 1'b0);
    end
    insn_done = 1'b1; rdy = 1'b0;
    @(negedge clk);
    chk("R3 not ready", busy, 1'b0);
    insn_done = 1'b0; rdy = 1'b1; irq_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_nmi();
    sp_in = 8'h80; pc_in = 16'h4321; status_in = 8'h01;
    imask = 1'b1; nmi_n = 1'b0;
    @(negedge clk);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    run_entry("R6 nmi", 16'hFFFA, 1'b1, 8'h80, 16'h4321, 8'h01);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    chk("R6 no retrigger", busy, 1'b0);
    nmi_n = 1'b1; imask = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_prio();
    sp_in = 8'h40; pc_in = 16'h0F0F; status_in = 8'h80;
    nmi_n = 1'b0;
    @(negedge clk);
    insn_done = 1'b1; irq_n = 1'b0;
    @(negedge clk);
    insn_done = 1'b0; nmi_n = 1'b1;
    run_entry("R7 nmi first", 16'hFFFA, 1'b1, 8'h40, 16'h0F0F, 8'h80);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_n = 1'b1;
    run_entry("R7 irq next", 16'hFFFE, 1'b1, 8'h40, 16'h0F0F, 8'h80);
  endtask

  task automatic t_nmi_during();
    sp_in = 8'h20; pc_in = 16'hC001; status_in = 8'h33;
    irq_n = 1'b0; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_n = 1'b1; nmi_n = 1'b0;
    run_entry("R8 irq", 16'hFFFE, 1'b1, 8'h20, 16'hC001, 8'h33);
    nmi_n = 1'b1;
    @(negedge clk);
    chk("R8 waits for boundary", busy, 1'b0);
    insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0;
    run_entry("R8 held nmi", 16'hFFFA, 1'b1, 8'h20, 16'hC001, 8'h33);
  endtask

  task automatic t_stall();
    sp_in = 8'hA0;
    irq_n = 1'b0; insn_done = 1'b1;
    @(negedge clk);
    insn_done = 1'b0; irq_n = 1'b1; rdy = 1'b0;
    chk("R9 write slot0", addr, 16'h01A0);
    @(negedge clk);
    chk("R9 write advances", addr, 16'h019F);
    @(negedge clk);
    chk("R9 write advances 2", addr, 16'h019E);
    @(negedge clk);
    chk("R9 read slot", addr, 16'hFFFE);
    chk("R10 mask at read", set_mask, 1'b1);
    @(negedge clk);
    chk("R9 read held", addr, 16'hFFFE);
    chk("R10 mask single", set_mask, 1'b0);
    @(negedge clk);
    chk("R9 read held 2", addr, 16'hFFFE);
    rdy = 1'b1;
    @(negedge clk);
    chk("R9 read resumes", addr, 16'hFFFF);
    @(negedge clk);
    chk("R9 load after stall", pc_load, 1'b1);
    chk("R9 pc after stall", pc_new, {mem_f(16'hFFFF), mem_f(16'hFFFE)});
    @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b1; irq_n = 1'b1; nmi_n = 1'b1; imask = 1'b0;
    insn_done = 1'b0; rdy = 1'b1;
    pc_in = 16'h1234; status_in = 8'hA5; sp_in = 8'hFD;
    #2 rst_n = 1'b0;
    t_reset();
    t_irq_basic();
    t_irq_blocked();
    t_nmi();
    t_prio();
    t_nmi_during();
    t_stall();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end
endmodule